// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox Controller

This block keeps a small register file for every core of a cluster: a pending-interrupt status word, an enable word, write-one-to-set and write-one-to-clear ports for the status, and eight 32-bit mailbox words. Each core has an interrupt line. The line is high while any status bit that is also enabled is set. A core reaches its own registers through a 32-bit window. The requester-ID input on the register-bus slave port tells the block which core's file the access goes to.

Three commands let one core act on another core. An interrupt-send command raises one vector in a target core. A mailbox-send command deposits a word into one of the target's mailbox words. An any-send command writes a word to any local register offset of the target. The mailbox and any-send commands are 64-bit writes. Each packs the target core, a location, a 32-bit data word and four per-byte keep bits. When any keep bit is set, the block reads the target word and merges into it before writing back. Every forwarded write is applied under the target core's identity, so it lands in the target's register file.

All accesses go through one command path, one at a time. A masked merge holds the port for one extra cycle, so no other command can come between its read and its write.

Top module: `ipi_mailbox_ctrl`

## Requirements
- R1: After reset, every status, enable and mailbox word is zero, every irq line is low, req_ready is high and rsp_valid is low.
- R2: A 4-byte access (req_wide=0) decodes req_addr[7:0] in the file of core req_rid:
  - 0x00 is status (read-only).
  - 0x04 is enable (read/write).
  - 0x08 is set.
  - 0x0C is clear.
  - 0x20+4*k, for k=0..7, is mailbox word k (read/write).
  - A read of any other offset, including 0x08, 0x0C and 0x40, returns zero with an OK response.
- R3: A write to the set offset ORs the data into status. A write to the clear offset clears every status bit whose data bit is 1.
- R4: irq[i] is high exactly when status and enable of core i share a set bit. The irq of a core that is not present stays low.
- R5: A 4-byte write to offset 0x40 is an interrupt send. It takes the target core from data bits 25:16 and the vector from bits 4:0, and sets only that status bit of the target.
- R6: A target number of NCORES or more, or one whose PRESENT bit is 0, returns rsp_code 3 (decode error) and changes no register. A 4-byte access from a requester whose req_rid is not a present core also returns rsp_code 3 and changes no register.
- R7: An 8-byte write at offset 0x048 is a mailbox send. It writes mailbox word cmd[4:2] of the target core given by cmd[25:16], using data cmd[63:32]. cmd[1:0] are ignored.
- R8: An 8-byte write at offset 0x158 is an any-send. It writes local offset cmd[7:0] of the target core with cmd[63:32], ignoring cmd[15:8]. The write follows the write rules of R2 and R3; a write to status or to an unassigned offset has no effect.
- R9: For both 8-byte commands, keep bit cmd[27+i] set means byte i of the target word keeps its old value, while bytes with a clear keep bit take the matching byte of cmd[63:32]. With all four keep bits clear, the whole word is replaced.
- R10: Every access except a masked forwarded command has its response one cycle after acceptance, with req_ready staying high. A masked forwarded command to a valid target drops req_ready for exactly one cycle and has its response two cycles after acceptance.
- R11: A write to an unassigned offset is ignored and responds OK (rsp_code 0). Any 8-byte access other than a write to 0x048 or 0x158 has no effect and responds OK with zero data.
- R12: A forwarded command changes only the target core's registers and never those of the requesting core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for an 8-byte access, 0 for a 4-byte access |
| req_addr | input | 12 | Register offset |
| req_wdata | input | 64 | Write data or command word |
| req_rid | input | 10 | Requester core ID |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 2 | 0 OK, 3 decode error |
| rsp_rdata | output | 32 | Read data, zero for writes |
| irq | output | NCORES | Per-core interrupt lines |

## Verification
A wrong status or enable bit shows on the irq lines in the same cycle as the response that caused it. A wrong mailbox word or a misapplied keep mask shows only when that word is read back. For that reason, every sweep is followed by reading back the whole register space of every present core. A forwarded write that reaches the wrong core file shows up in that same full read-back, because the originator's file is compared as well as the target's. A merge that does not hold the port shows as a response one cycle too early.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;

    localparam int DW   = 32;
    localparam int CW   = 64;
    localparam int IDW  = 10;
    localparam int AW   = 12;
    localparam int NBUF = 8;

    localparam logic [7:0]  OFF_STATUS = 8'h00;
    localparam logic [7:0]  OFF_ENABLE = 8'h04;
    localparam logic [7:0]  OFF_SET    = 8'h08;
    localparam logic [7:0]  OFF_CLEAR  = 8'h0C;
    localparam logic [7:0]  OFF_BUF0   = 8'h20;
    localparam logic [7:0]  OFF_RAISE  = 8'h40;
    localparam logic [AW-1:0] WOFF_MAIL = 12'h048;
    localparam logic [AW-1:0] WOFF_ANY  = 12'h158;

    typedef enum logic [1:0] {
        RSP_OK     = 2'd0,
        RSP_DECERR = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_READ,
        OP_WRITE,
        OP_ERR
    } op_e;

    typedef struct packed {
        op_e              kind;
        logic [IDW-1:0]   core;
        logic [7:0]       off;
        logic [DW-1:0]    data;
        logic [3:0]       keep;
    } op_t;

    function automatic logic is_buf_off(input logic [7:0] off);
        return (off[7:5] == 3'b001) && (off[1:0] == 2'b00);
    endfunction

    function automatic logic [DW-1:0] keep_mask(input logic [3:0] k);
        logic [DW-1:0] m;
        for (int i = 0; i < 4; i++) begin
            m[8*i +: 8] = {8{k[i]}};
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] merge_word(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [3:0]    k);
        logic [DW-1:0] m;
        m = keep_mask(k);
        return (old_w & m) | (new_w & ~m);
    endfunction

endpackage

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
    import ipi_mbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_off,
    input  logic [DW-1:0] wr_data,
    input  logic [7:0]    rd_off,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    localparam int BIW = $clog2(NBUF);

    logic [DW-1:0] status_q;
    logic [DW-1:0] enable_q;
    logic [DW-1:0] mbox_q [NBUF];

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
            for (int i = 0; i < NBUF; i++) begin
                mbox_q[i] <= '0;
            end
        end else if (wr_en) begin
            case (wr_off)
                OFF_ENABLE: enable_q <= wr_data;
                OFF_SET:    status_q <= status_q | wr_data;
                OFF_CLEAR:  status_q <= status_q & ~wr_data;
                default: begin
                    if (is_buf_off(wr_off)) begin
                        mbox_q[wr_off[BIW+1:2]] <= wr_data;
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (rd_off)
            OFF_STATUS: rd_data = status_q;
            OFF_ENABLE: rd_data = enable_q;
            default:    rd_data = is_buf_off(rd_off) ? mbox_q[rd_off[BIW+1:2]] : '0;
        endcase
    end

    assign irq = |(status_q & enable_q);

endmodule

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_mbox_pkg::*;
#(
    parameter int                 NCORES  = 4,
    parameter logic [NCORES-1:0]  PRESENT = '1
) (
    input  logic           req_write,
    input  logic           req_wide,
    input  logic [AW-1:0]  req_addr,
    input  logic [CW-1:0]  req_wdata,
    input  logic [IDW-1:0] req_rid,
    output op_t            op
);
    function automatic logic core_exists(input logic [IDW-1:0] id);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NCORES; i++) begin
            if (id == IDW'(i) && PRESENT[i]) r = 1'b1;
        end
        return r;
    endfunction

    logic [IDW-1:0] tgt;
    logic [7:0]     local_off;
    logic           raise_cmd;
    logic           fwd_cmd;

    assign tgt       = req_wdata[25:16];
    assign local_off = req_addr[7:0];
    assign raise_cmd = !req_wide && req_write && (local_off == OFF_RAISE);
    assign fwd_cmd   = req_wide && req_write &&
                       ((req_addr == WOFF_MAIL) || (req_addr == WOFF_ANY));

    always_comb begin
        op      = '0;
        op.kind = OP_NOP;
        if (!req_wide) begin
            if (!core_exists(req_rid)) begin
                op.kind = OP_ERR;
            end else if (!req_write) begin
                op.kind = OP_READ;
                op.core = req_rid;
                op.off  = local_off;
            end else if (raise_cmd) begin
                if (core_exists(tgt)) begin
                    op.kind = OP_WRITE;
                    op.core = tgt;
                    op.off  = OFF_SET;
                    op.data = DW'(1) << req_wdata[4:0];
                end else begin
                    op.kind = OP_ERR;
                end
            end else if (local_off == OFF_ENABLE || local_off == OFF_SET ||
                         local_off == OFF_CLEAR  || is_buf_off(local_off)) begin
                op.kind = OP_WRITE;
                op.core = req_rid;
                op.off  = local_off;
                op.data = req_wdata[DW-1:0];
            end
        end else if (fwd_cmd) begin
            if (core_exists(tgt)) begin
                op.kind = OP_WRITE;
                op.core = tgt;
                op.off  = (req_addr == WOFF_MAIL) ?
                          (OFF_BUF0 | {3'b000, req_wdata[4:2], 2'b00}) :
                          req_wdata[7:0];
                op.data = req_wdata[63:32];
                op.keep = req_wdata[30:27];
            end else begin
                op.kind = OP_ERR;
            end
        end
    end

endmodule

// File: rtl/ipi_cmd_path.sv
module ipi_cmd_path
    import ipi_mbox_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  op_t            op,
    output logic           req_ready,
    output logic           wr_en,
    output logic [IDW-1:0] wr_core,
    output logic [7:0]     wr_off,
    output logic [DW-1:0]  wr_data,
    output logic [IDW-1:0] rd_core,
    output logic [7:0]     rd_off,
    input  logic [DW-1:0]  rd_data,
    output logic           rsp_valid,
    output rsp_e           rsp_code,
    output logic [DW-1:0]  rsp_rdata
);
    logic busy_q;
    op_t  pend_q;
    logic accept;
    logic masked;

    assign req_ready = !busy_q;
    assign accept    = req_valid && !busy_q;
    assign masked    = (op.kind == OP_WRITE) && (op.keep != 4'b0000);

    always_comb begin
        rd_core = busy_q ? pend_q.core : op.core;
        rd_off  = busy_q ? pend_q.off  : op.off;
        wr_en   = 1'b0;
        wr_core = op.core;
        wr_off  = op.off;
        wr_data = op.data;
        if (busy_q) begin
            wr_en   = 1'b1;
            wr_core = pend_q.core;
            wr_off  = pend_q.off;
            wr_data = merge_word(rd_data, pend_q.data, pend_q.keep);
        end else if (accept && op.kind == OP_WRITE && !masked) begin
            wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            pend_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
            rsp_rdata <= '0;
            if (busy_q) begin
                busy_q    <= 1'b0;
                rsp_valid <= 1'b1;
            end else if (accept) begin
                if (masked) begin
                    busy_q <= 1'b1;
                    pend_q <= op;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_code  <= (op.kind == OP_ERR) ? RSP_DECERR : RSP_OK;
                    rsp_rdata <= (op.kind == OP_READ) ? rd_data : '0;
                end
            end
        end
    end

endmodule

// File: rtl/ipi_mailbox_ctrl.sv
module ipi_mailbox_ctrl
    import ipi_mbox_pkg::*;
#(
    parameter int                NCORES  = 4,
    parameter logic [NCORES-1:0] PRESENT = 4'b1011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [11:0]       req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [9:0]        req_rid,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [31:0]       rsp_rdata,
    output logic [NCORES-1:0] irq
);
    op_t            op;
    logic           wr_en;
    logic [IDW-1:0] wr_core;
    logic [7:0]     wr_off;
    logic [DW-1:0]  wr_data;
    logic [IDW-1:0] rd_core;
    logic [7:0]     rd_off;
    logic [DW-1:0]  rd_sel;
    logic [DW-1:0]  rd_core_data [NCORES];
    rsp_e           code_e;

    ipi_cmd_decode #(.NCORES(NCORES), .PRESENT(PRESENT)) u_dec (
        .req_write (req_write),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_rid   (req_rid),
        .op        (op)
    );

    ipi_cmd_path u_path (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .op        (op),
        .req_ready (req_ready),
        .wr_en     (wr_en),
        .wr_core   (wr_core),
        .wr_off    (wr_off),
        .wr_data   (wr_data),
        .rd_core   (rd_core),
        .rd_off    (rd_off),
        .rd_data   (rd_sel),
        .rsp_valid (rsp_valid),
        .rsp_code  (code_e),
        .rsp_rdata (rsp_rdata)
    );

    assign rsp_code = code_e;

    for (genvar g = 0; g < NCORES; g++) begin : g_core
        if (PRESENT[g]) begin : g_on
            ipi_core_regs u_regs (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_en && (wr_core == IDW'(g))),
                .wr_off  (wr_off),
                .wr_data (wr_data),
                .rd_off  (rd_off),
                .rd_data (rd_core_data[g]),
                .irq     (irq[g])
            );
        end else begin : g_off
            assign rd_core_data[g] = '0;
            assign irq[g]          = 1'b0;
        end
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (rd_core == IDW'(i)) rd_sel = rd_core_data[i];
        end
    end

endmodule

// File: rtl/ipi_mbox_chk.sv
module ipi_mbox_chk
    import ipi_mbox_pkg::*;
#(
    parameter int                NCORES  = 4,
    parameter logic [NCORES-1:0] PRESENT = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              req_wide,
    input logic [11:0]       req_addr,
    input logic [63:0]       req_wdata,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic [NCORES-1:0] irq
);
    logic fwd_masked;
    assign fwd_masked = req_valid && req_ready && req_wide && req_write &&
                        (req_addr == WOFF_MAIL || req_addr == WOFF_ANY) &&
                        (req_wdata[30:27] != 4'b0000);

    // R1: reset leaves outputs idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (irq == '0 && !rsp_valid && req_ready));

    // R4: absent cores never interrupt
    a_r4_absent_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq & ~PRESENT) == '0);

    // R6: a decode error leaves the interrupt lines unchanged
    a_r6_err_no_irq_change: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd3) |-> $stable(irq));

    // R10: the port is held for at most one cycle
    a_r10_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);

    // R10: unmasked accesses respond on the next cycle
    a_r10_plain_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !fwd_masked) |=> rsp_valid);

    // R10: masked forwards hold the port unless rejected
    a_r10_masked_holds: assert property (@(posedge clk) disable iff (rst)
        fwd_masked |=> (!req_ready || (rsp_valid && rsp_code == 2'd3)));

    // R10: every response has a cause
    a_r10_rsp_caused: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready)));

    // R6: only the two defined codes appear
    a_r6_code_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_code == 2'd0 || rsp_code == 2'd3));

endmodule

bind ipi_mailbox_ctrl ipi_mbox_chk #(.NCORES(NCORES), .PRESENT(PRESENT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_wide  (req_wide),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .irq       (irq)
);

// File: tb/tb_ipi_mailbox_ctrl.sv
`timescale 1ns/1ps
module tb_ipi_mailbox_ctrl;
    localparam int NC = 4;
    localparam logic [NC-1:0] PRES = 4'b1011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [9:0]  req_rid = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_rdata;
    logic [NC-1:0] irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] m_st [NC];
    logic [31:0] m_en [NC];
    logic [31:0] m_bf [NC][8];

    always #2.5 clk = ~clk;

    ipi_mailbox_ctrl #(.NCORES(NC), .PRESENT(PRES)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_rid(req_rid), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit live(input int id);
        return (id >= 0) && (id < NC) && PRES[id];
    endfunction

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] k);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = k[i] ? o[8*i +: 8] : n[8*i +: 8];
        return r;
    endfunction

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] r;
        for (int i = 0; i < NC; i++) r[i] = live(i) && ((m_st[i] & m_en[i]) != 0);
        return r;
    endfunction

    function automatic logic [63:0] cmd(input logic [31:0] d, input logic [3:0] k,
                                        input int tgt, input logic [15:0] lo);
        return {d, 1'b0, k, 1'b0, 10'(tgt), lo};
    endfunction

    task automatic access(input bit wide, input bit wr, input logic [11:0] a,
                          input logic [63:0] d, input int rid,
                          output logic [1:0] code, output logic [31:0] rd,
                          output int lat, output bit held);
        bit acc;
        @(negedge clk);
        req_valid = 1'b1; req_wide = wide; req_write = wr;
        req_addr = a; req_wdata = d; req_rid = 10'(rid);
        lat = 0; held = 0;
        do begin
            acc = req_ready;
            @(negedge clk);
            lat++;
        end while (!acc && lat < 50);
        req_valid = 1'b0;
        while (!rsp_valid && lat < 50) begin
            if (!req_ready) held = 1;
            @(negedge clk);
            lat++;
        end
        code = rsp_code; rd = rsp_rdata;
    endtask

    task automatic wr32(input logic [7:0] off, input logic [31:0] d, input int rid,
                        input logic [1:0] ecode, input string req);
        logic [1:0] c; logic [31:0] r; int l; bit h;
        access(0, 1, {4'h0, off}, {32'h0, d}, rid, c, r, l, h);
        chk(c == ecode && l == 1, req, "wr32 code/latency", {c, 30'(l)}, {ecode, 30'd1});
    endtask

    task automatic rd_chk(input logic [7:0] off, input int rid,
                          input logic [31:0] exp, input string req);
        logic [1:0] c; logic [31:0] r; int l; bit h;
        access(0, 0, {4'h0, off}, 64'h0, rid, c, r, l, h);
        chk(c == 2'd0 && r == exp, req, $sformatf("read core%0d off%h", rid, off), r, exp);
    endtask

    task automatic compare_all(input string req);
        for (int c = 0; c < NC; c++) begin
            if (live(c)) begin
                rd_chk(8'h00, c, m_st[c], req);
                rd_chk(8'h04, c, m_en[c], req);
                for (int w = 0; w < 8; w++) rd_chk(8'(8'h20 + 4 * w), c, m_bf[c][w], req);
            end
        end
        chk(irq == exp_irq(), req, "irq lines", 64'(irq), 64'(exp_irq()));
    endtask

    task automatic fwd(input logic [11:0] a, input logic [63:0] d, input int rid,
                       input string req);
        logic [1:0] c; logic [31:0] r; int l; bit h; int tgt; logic [3:0] k;
        logic [7:0] off; int el;
        tgt = int'(d[25:16]); k = d[30:27];
        off = (a == 12'h048) ? 8'(8'h20 + {d[4:2], 2'b00}) : d[7:0];
        el = (live(tgt) && k != 0) ? 2 : 1;
        access(1, 1, a, d, rid, c, r, l, h);
        chk(c == (live(tgt) ? 2'd0 : 2'd3), req, "forward code", c, live(tgt) ? 0 : 3);
        chk(l == el && h == (el == 2), "R10", "forward latency/hold", l, el);
        if (live(tgt)) begin
            case (off)
                8'h04: m_en[tgt] = mrg(m_en[tgt], d[63:32], k);
                8'h08: m_st[tgt] = m_st[tgt] | mrg(32'h0, d[63:32], k);
                8'h0C: m_st[tgt] = m_st[tgt] & ~mrg(32'h0, d[63:32], k);
                default: if (off[7:5] == 3'b001 && off[1:0] == 0)
                    m_bf[tgt][off[4:2]] = mrg(m_bf[tgt][off[4:2]], d[63:32], k);
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] c; logic [31:0] r; int l; bit h;
        for (int i = 0; i < NC; i++) begin
            m_st[i] = 0; m_en[i] = 0;
            for (int w = 0; w < 8; w++) m_bf[i][w] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(irq == 0 && req_ready && !rsp_valid, "R1", "reset outputs",
            {irq, req_ready, rsp_valid}, {4'h0, 2'b10});
        rst = 1'b0;
        compare_all("R1");

        // R2: own-window writes and readback
        for (int cc = 0; cc < NC; cc++) begin
            if (live(cc)) begin
                wr32(8'h04, 32'h0 ^ (32'h11111111 * (cc + 1)), cc, 2'd0, "R2");
                m_en[cc] = 32'h11111111 * (cc + 1);
                for (int w = 0; w < 8; w++) begin
                    wr32(8'(8'h20 + 4 * w), 32'hA5000000 + 32'(cc * 16 + w), cc, 2'd0, "R2");
                    m_bf[cc][w] = 32'hA5000000 + 32'(cc * 16 + w);
                end
            end
        end
        compare_all("R2");
        rd_chk(8'h08, 0, 32'h0, "R2");
        rd_chk(8'h0C, 0, 32'h0, "R2");
        rd_chk(8'h40, 0, 32'h0, "R2");
        rd_chk(8'h14, 0, 32'h0, "R2");

        // R3 and R4: set/clear and interrupt lines
        wr32(8'h00, 32'hFFFFFFFF, 0, 2'd0, "R3");
        wr32(8'h08, 32'h00F0000E, 0, 2'd0, "R3"); m_st[0] = 32'h00F0000E;
        wr32(8'h0C, 32'h00300006, 0, 2'd0, "R3"); m_st[0] = 32'h00C00008;
        compare_all("R3");
        wr32(8'h04, 32'h00000001, 0, 2'd0, "R4"); m_en[0] = 32'h1;
        compare_all("R4");
        wr32(8'h04, 32'h00800000, 0, 2'd0, "R4"); m_en[0] = 32'h00800000;
        compare_all("R4");
        wr32(8'h0C, 32'hFFFFFFFF, 0, 2'd0, "R4"); m_st[0] = 0;
        compare_all("R4");

        // R5 and R6: interrupt-send sweep over requester, target and vector
        for (int s = 0; s < NC; s++) begin
            for (int t = 0; t < NC; t++) begin
                for (int v = 0; v < 32; v++) begin
                    bit ok;
                    ok = live(s) && live(t);
                    access(0, 1, 12'h040, {32'h0, 6'h0, 10'(t), 11'h0, 5'(v)}, s, c, r, l, h);
                    chk(c == (ok ? 2'd0 : 2'd3) && l == 1, ok ? "R5" : "R6",
                        "raise code", c, ok ? 0 : 3);
                    if (ok) m_st[t] = m_st[t] | (32'h1 << v);
                    if (ok && v == 0) begin
                        rd_chk(8'h00, t, m_st[t], "R5");
                    end
                end
                if (live(t)) begin
                    rd_chk(8'h00, t, m_st[t], "R5");
                    chk(irq == exp_irq(), "R4", "irq after raise", irq, exp_irq());
                    wr32(8'h0C, 32'hFFFFFFFF, t, 2'd0, "R3"); m_st[t] = 0;
                end
            end
        end
        compare_all("R5");

        // R6: bad targets on every command leave all state alone
        wr32(8'h40, {6'h0, 10'd4, 16'h0003}, 0, 2'd3, "R6");
        wr32(8'h40, {6'h0, 10'd1023, 16'h0003}, 1, 2'd3, "R6");
        fwd(12'h048, cmd(32'hDEADBEEF, 4'h0, 2, 16'h0004), 0, "R6");
        fwd(12'h158, cmd(32'hDEADBEEF, 4'h3, 4, 16'h0004), 0, "R6");
        fwd(12'h158, cmd(32'hDEADBEEF, 4'h0, 1023, 16'h0008), 3, "R6");
        wr32(8'h04, 32'hFFFFFFFF, 2, 2'd3, "R6");
        compare_all("R6");

        // R7 and R12: mailbox sweep, originator differs from target
        for (int t = 0; t < NC; t++) begin
            if (live(t)) begin
                for (int w = 0; w < 8; w++) begin
                    fwd(12'h048, cmd(32'h3C000000 + 32'(t * 256 + w), 4'h0, t,
                                     16'(w * 4 + 3)), (t + 1) % NC, "R7");
                end
            end
        end
        compare_all("R12");

        // R9: every keep mask on one word
        for (int k = 0; k < 16; k++) begin
            fwd(12'h048, cmd(32'h01020304 * 32'(k + 1), 4'(k), 1, 16'h000C), 0, "R9");
            rd_chk(8'h2C, 1, m_bf[1][3], "R9");
        end
        compare_all("R9");

        // R8: any-send to several local offsets, upper address bits ignored
        fwd(12'h158, cmd(32'h0000F00F, 4'h0, 3, 16'h1004), 0, "R8");
        fwd(12'h158, cmd(32'h00000F01, 4'h0, 3, 16'hFF08), 1, "R8");
        fwd(12'h158, cmd(32'h00000100, 4'h0, 3, 16'h000C), 0, "R8");
        fwd(12'h158, cmd(32'hFFFFFFFF, 4'h0, 3, 16'h0000), 0, "R8");
        fwd(12'h158, cmd(32'hCAFE0000, 4'h5, 3, 16'h003C), 1, "R8");
        fwd(12'h158, cmd(32'h12345678, 4'hA, 0, 16'h0004), 3, "R8");
        compare_all("R8");

        // R11: unassigned offsets and non-command 8-byte accesses
        wr32(8'h10, 32'hFFFFFFFF, 0, 2'd0, "R11");
        wr32(8'h48, 32'hFFFFFFFF, 1, 2'd0, "R11");
        access(1, 0, 12'h048, 64'h0, 0, c, r, l, h);
        chk(c == 0 && r == 0 && l == 1, "R11", "wide read", {c, r}, 0);
        access(1, 1, 12'h050, cmd(32'hFFFFFFFF, 4'h0, 0, 16'h0020), 0, c, r, l, h);
        chk(c == 0 && l == 1, "R11", "wide write other offset", c, 0);
        access(1, 1, 12'h004, cmd(32'hFFFFFFFF, 4'h0, 0, 16'h0020), 0, c, r, l, h);
        chk(c == 0 && l == 1, "R11", "wide write to enable offset", c, 0);
        compare_all("R11");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule